// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Large-Page Tracking

This block caches finished address translations for a page walker. Each slot holds a tag, a page-size mask, a physical frame number and a small field of access bits. A slot is chosen by the low bits of the linear page number, and a lookup hits when the linear address, with the slot's page-offset bits cleared, equals the stored tag. Pages of 4 KiB and any larger power-of-two size share the same array. The mask tells them apart.

A large page is filed under the index of the address that was walked, so other 4 KiB pieces of the same page map to other slots. A single-address invalidate therefore cannot know which slot holds a stale large mapping. The block keeps one sticky flag that is set whenever a large translation may be cached. While that flag is set, a single-address invalidate clears the whole array. While it is clear, the invalidate clears one slot. A full flush empties the array and tells the walker to drop its cached pointer-table entries. A non-global flush sweeps the array one slot per cycle. It keeps the entries marked global and rebuilds the flag from the large entries that survive.

Lookup, fill and invalidate are valid/ready requests. A request is taken on a rising edge where both its valid and its ready are high. No request is accepted while a sweep runs or while either flush input is high. The lookup response has no back-pressure: the consumer must take it in the cycle it appears. The flush inputs, `busy`, `large_present` and `walk_cache_clr` are plain control and status pins.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, so every lookup misses. Also, `busy` and `large_present` are low.
- R2: `lk_ready`, `fill_ready` and `inv_ready` are low while `busy`, `flush_all` or `flush_local` is high. `fill_ready` is also low while `inv_valid` is high. An accepted lookup gives `rsp_valid` high in the next cycle, and the result reflects the array as it was before that edge.
- R3: The slot index is `addr[12 +: log2(SLOTS)]`. A lookup hits when `(addr & ~mask) == tag`. On a hit, `rsp_paddr = {frame, 12'h000} | (addr & mask)` and `rsp_acc` returns the stored access bits.
- R4: An accepted fill writes its slot. The stored mask is `fill_mask | 12'hFFF`, and the stored tag is `fill_addr` with the mask bits cleared. A fill offered in the same cycle as an invalidate is not accepted.
- R5: An accepted fill whose mask is above `12'hFFF` sets `large_present` in the next cycle.
- R6: `flush_all` empties every slot and clears `large_present`. It cancels a running sweep and raises `walk_cache_clr` for exactly the next cycle. When `flush_all` and `flush_local` are high together, `flush_all` wins.
- R7: `flush_local` taken while idle raises `busy` for exactly SLOTS cycles, starting the next cycle. The sweep empties every slot whose global bit (bit 2 of the access field) is 0 and keeps the others. `flush_local` is ignored while `busy` is high.
- R8: A sweep clears `large_present` when it starts. It sets the flag again for each surviving global entry whose mask is above `12'hFFF`.
- R9: An accepted invalidate while `large_present` is high empties every slot and clears `large_present`.
- R10: An accepted invalidate while `large_present` is low empties only the slot indexed by `inv_addr`, and only if that slot matches the address under the R3 rule. Every other slot is untouched.
- R11: An empty slot holds the tag value 1. A page-aligned tag cannot equal 1, so an empty slot never hits, not even for address 0 or address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_addr | input | LA_W | Linear address to look up |
| rsp_valid | output | 1 | Lookup result valid (one cycle after acceptance) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | PA_W | Physical address on a hit |
| rsp_acc | output | ACC_W | Access bits of the hitting slot |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill request can be taken |
| fill_addr | input | LA_W | Linear address that was walked |
| fill_frame | input | PA_W-12 | Physical frame number |
| fill_mask | input | LA_W | Page-offset mask (0xFFF for 4 KiB) |
| fill_acc | input | ACC_W | Access bits; bit 2 marks a global page |
| inv_valid | input | 1 | Single-address invalidate valid |
| inv_ready | output | 1 | Invalidate can be taken |
| inv_addr | input | LA_W | Address to invalidate |
| flush_all | input | 1 | Empty the whole cache |
| flush_local | input | 1 | Start a sweep that drops non-global entries |
| busy | output | 1 | Sweep in progress |
| large_present | output | 1 | A large translation may be cached |
| walk_cache_clr | output | 1 | Pulse telling the walker to drop its pointer-table cache |

## Verification
The bench uses several hit patterns. Lookups at different offsets within a 4 KiB page check the offset merge. A lookup at the same index with a different tag separates index from tag. A lookup inside a 2 MiB page checks the mask merge. Invalidates are issued with the large-page flag both set and clear, and with matching and mismatching tags, to show the difference between a whole-array clear and a single-slot clear. Sweeps run over mixes of global, non-global, small and large entries to show which entries survive and how the flag is rebuilt. One sweep is cut short by a full flush. A long pseudo-random phase mixes every request, including requests that collide in the same cycle, so that readiness priority is exercised against the cycle model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned PG_BITS = 12;
  localparam int unsigned GLB_BIT = 2;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_FLUSH,
    CMD_START,
    CMD_SWEEP,
    CMD_INV,
    CMD_FILL
  } xlat_cmd_e;
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp #(
  parameter int unsigned LA_W = 32
) (
  input  logic [LA_W-1:0] addr,
  input  logic [LA_W-1:0] tag,
  input  logic [LA_W-1:0] mask,
  output logic            hit
);
  // The stored mask always covers the 4 KiB offset, so the masked address is page aligned
  assign hit = ((addr & ~mask) == tag);
endmodule

// File: rtl/xlat_sweep.sv
module xlat_sweep #(
  parameter int unsigned SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     abort,
  output logic                     busy,
  output logic [$clog2(SLOTS)-1:0] idx
);
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R7
  sweep_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && idx == LAST && !abort |=> !busy);
  // R7
  sweep_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort && !busy |=> busy && idx == '0);
endmodule

// File: rtl/xlat_large_track.sv
module xlat_large_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned LA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned ACC_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [LA_W-1:0]          lk_addr,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [PA_W-1:0]          rsp_paddr,
  output logic [ACC_W-1:0]         rsp_acc,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [LA_W-1:0]          fill_addr,
  input  logic [PA_W-PG_BITS-1:0]  fill_frame,
  input  logic [LA_W-1:0]          fill_mask,
  input  logic [ACC_W-1:0]         fill_acc,
  input  logic                     inv_valid,
  output logic                     inv_ready,
  input  logic [LA_W-1:0]          inv_addr,
  input  logic                     flush_all,
  input  logic                     flush_local,
  output logic                     busy,
  output logic                     large_present,
  output logic                     walk_cache_clr
);
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned FRM_W = PA_W - PG_BITS;
  localparam logic [LA_W-1:0] OFS_MASK = LA_W'((64'd1 << PG_BITS) - 64'd1);
  localparam logic [LA_W-1:0] BAD_TAG  = LA_W'(1);

  logic [LA_W-1:0]  tag_q  [SLOTS];
  logic [LA_W-1:0]  mask_q [SLOTS];
  logic [FRM_W-1:0] frm_q  [SLOTS];
  logic [ACC_W-1:0] acc_q  [SLOTS];

  // ---------------- request acceptance and command decode
  logic base_rdy, lk_go, inv_go, fill_go;
  xlat_cmd_e cmd;

  assign base_rdy   = !busy && !flush_all && !flush_local;
  assign lk_ready   = base_rdy;
  assign inv_ready  = base_rdy;
  assign fill_ready = base_rdy && !inv_valid;
  assign lk_go      = lk_valid && lk_ready;
  assign inv_go     = inv_valid && inv_ready;
  assign fill_go    = fill_valid && fill_ready;

  always_comb begin
    if (flush_all)        cmd = CMD_FLUSH;
    else if (busy)        cmd = CMD_SWEEP;
    else if (flush_local) cmd = CMD_START;
    else if (inv_go)      cmd = CMD_INV;
    else if (fill_go)     cmd = CMD_FILL;
    else                  cmd = CMD_IDLE;
  end

  // ---------------- sweep sequencer and large-page flag
  logic [IDX_W-1:0] sw_idx;

  xlat_sweep #(.SLOTS(SLOTS)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd == CMD_START),
    .abort (cmd == CMD_FLUSH),
    .busy  (busy),
    .idx   (sw_idx)
  );

  logic sw_valid, sw_kill, sw_keep_large;
  assign sw_valid      = (tag_q[sw_idx] != BAD_TAG);
  assign sw_kill       = (cmd == CMD_SWEEP) && sw_valid && !acc_q[sw_idx][GLB_BIT];
  assign sw_keep_large = (cmd == CMD_SWEEP) && sw_valid && acc_q[sw_idx][GLB_BIT]
                         && (mask_q[sw_idx] > OFS_MASK);

  // ---------------- invalidate decision
  logic [IDX_W-1:0] inv_idx;
  logic             inv_match, inv_all, inv_one;
  assign inv_idx = inv_addr[PG_BITS +: IDX_W];

  xlat_tag_cmp #(.LA_W(LA_W)) u_inv_cmp (
    .addr (inv_addr),
    .tag  (tag_q[inv_idx]),
    .mask (mask_q[inv_idx]),
    .hit  (inv_match)
  );

  assign inv_all = (cmd == CMD_INV) && large_present;
  assign inv_one = (cmd == CMD_INV) && !large_present && inv_match;

  // ---------------- fill data
  logic [IDX_W-1:0] fill_idx;
  logic [LA_W-1:0]  fill_mask_n, fill_tag;
  logic             fill_large;
  assign fill_idx    = fill_addr[PG_BITS +: IDX_W];
  assign fill_mask_n = fill_mask | OFS_MASK;
  assign fill_tag    = fill_addr & ~fill_mask_n;
  assign fill_large  = fill_mask_n > OFS_MASK;

  xlat_large_track u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((cmd == CMD_FLUSH) || (cmd == CMD_START) || inv_all),
    .set   (sw_keep_large || ((cmd == CMD_FILL) && fill_large)),
    .flag  (large_present)
  );

  // ---------------- per-slot write enables
  logic [SLOTS-1:0] wipe, wr;
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign wipe[g] = (cmd == CMD_FLUSH) || inv_all
                     || (sw_kill && sw_idx == IDX_W'(g))
                     || (inv_one && inv_idx == IDX_W'(g));
    assign wr[g]   = (cmd == CMD_FILL) && fill_idx == IDX_W'(g);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (!rst_n) begin
        tag_q[s]  <= BAD_TAG;
        mask_q[s] <= OFS_MASK;
        frm_q[s]  <= '0;
        acc_q[s]  <= '0;
      end else if (wipe[s]) begin
        tag_q[s] <= BAD_TAG;
      end else if (wr[s]) begin
        tag_q[s]  <= fill_tag;
        mask_q[s] <= fill_mask_n;
        frm_q[s]  <= fill_frame;
        acc_q[s]  <= fill_acc;
      end
    end
  end

  // ---------------- lookup response
  logic [IDX_W-1:0] lk_idx;
  logic             lk_match;
  assign lk_idx = lk_addr[PG_BITS +: IDX_W];

  xlat_tag_cmp #(.LA_W(LA_W)) u_lk_cmp (
    .addr (lk_addr),
    .tag  (tag_q[lk_idx]),
    .mask (mask_q[lk_idx]),
    .hit  (lk_match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_paddr      <= '0;
      rsp_acc        <= '0;
      walk_cache_clr <= 1'b0;
    end else begin
      rsp_valid      <= lk_go;
      rsp_hit        <= lk_go && lk_match;
      rsp_paddr      <= {frm_q[lk_idx], {PG_BITS{1'b0}}} | PA_W'(lk_addr & mask_q[lk_idx]);
      rsp_acc        <= acc_q[lk_idx];
      walk_cache_clr <= (cmd == CMD_FLUSH);
    end
  end

  // R6
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !large_present && walk_cache_clr && !busy);
  // R5
  large_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready && (fill_mask > OFS_MASK) |=> large_present);
  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);
  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_ready && !fill_ready && !inv_ready);
  // R9
  inv_large_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && large_present |=> !large_present);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, fill_valid = 0, inv_valid = 0, flush_all = 0, flush_local = 0;
  logic [31:0] lk_addr = 0, fill_addr = 0, fill_mask = 0, inv_addr = 0;
  logic [19:0] fill_frame = 0;
  logic [2:0]  fill_acc = 0;
  logic        lk_ready, fill_ready, inv_ready, rsp_valid, rsp_hit;
  logic        busy, large_present, walk_cache_clr;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_acc;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_acc(rsp_acc),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_frame(fill_frame), .fill_mask(fill_mask), .fill_acc(fill_acc),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
    .flush_all(flush_all), .flush_local(flush_local),
    .busy(busy), .large_present(large_present), .walk_cache_clr(walk_cache_clr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model
  logic [31:0] m_tag [16];
  logic [31:0] m_mask[16];
  logic [19:0] m_frm [16];
  logic [2:0]  m_acc [16];
  bit m_flag, m_busy, e_rv, e_hit, e_walk;
  int m_cnt;
  logic [31:0] e_pa;
  logic [2:0]  e_acc;

  always @(posedge clk) begin
    bit rdy, lg, ig, fg;
    int i;
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin
        m_tag[k] = 32'h1; m_mask[k] = 32'hFFF; m_frm[k] = 0; m_acc[k] = 0;
      end
      m_flag = 0; m_busy = 0; m_cnt = 0; e_rv = 0; e_hit = 0; e_walk = 0;
    end else begin
      rdy = !m_busy && !flush_all && !flush_local;
      lg = lk_valid && rdy; ig = inv_valid && rdy; fg = fill_valid && rdy && !inv_valid;
      e_rv = lg; e_walk = flush_all; e_hit = 0;
      if (lg) begin
        i = int'(lk_addr[15:12]);
        e_hit = ((lk_addr & ~m_mask[i]) == m_tag[i]);
        e_pa  = {m_frm[i], 12'h000} | (lk_addr & m_mask[i]);
        e_acc = m_acc[i];
      end
      if (flush_all) begin
        for (int k = 0; k < 16; k++) m_tag[k] = 32'h1;
        m_flag = 0; m_busy = 0;
      end else if (m_busy) begin
        if (m_tag[m_cnt] != 32'h1) begin
          if (!m_acc[m_cnt][2]) m_tag[m_cnt] = 32'h1;
          else if (m_mask[m_cnt] > 32'hFFF) m_flag = 1;
        end
        m_cnt++;
        if (m_cnt == 16) m_busy = 0;
      end else if (flush_local) begin
        m_busy = 1; m_cnt = 0; m_flag = 0;
      end else if (ig) begin
        if (m_flag) begin
          for (int k = 0; k < 16; k++) m_tag[k] = 32'h1;
          m_flag = 0;
        end else begin
          i = int'(inv_addr[15:12]);
          if ((inv_addr & ~m_mask[i]) == m_tag[i]) m_tag[i] = 32'h1;
        end
      end else if (fg) begin
        i = int'(fill_addr[15:12]);
        m_mask[i] = fill_mask | 32'hFFF;
        m_tag[i]  = fill_addr & ~m_mask[i];
        m_frm[i]  = fill_frame;
        m_acc[i]  = fill_acc;
        if (m_mask[i] > 32'hFFF) m_flag = 1;
      end
    end
  end

  // cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    bit rdy;
    #1;
    if (rst_n) begin
      rdy = !m_busy && !flush_all && !flush_local;
      check(lk_ready == rdy, "R2 lk_ready", 32'(lk_ready), 32'(rdy));
      check(inv_ready == rdy, "R2 inv_ready", 32'(inv_ready), 32'(rdy));
      check(fill_ready == (rdy && !inv_valid), "R2 fill_ready", 32'(fill_ready), 32'(rdy && !inv_valid));
      check(busy == m_busy, "R7 busy", 32'(busy), 32'(m_busy));
      check(large_present == m_flag, "R8 large_present", 32'(large_present), 32'(m_flag));
      check(walk_cache_clr == e_walk, "R6 walk_cache_clr", 32'(walk_cache_clr), 32'(e_walk));
      check(rsp_valid == e_rv, "R2 rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) begin
        check(rsp_hit == e_hit, "R3 rsp_hit", 32'(rsp_hit), 32'(e_hit));
        if (e_hit) begin
          check(rsp_paddr == e_pa, "R3 rsp_paddr", rsp_paddr, e_pa);
          check(rsp_acc == e_acc, "R3 rsp_acc", 32'(rsp_acc), 32'(e_acc));
        end
      end
    end
  end

  // ---------------- directed stimulus helpers
  task automatic idle_all();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_all = 0; flush_local = 0;
  endtask

  task automatic look(input logic [31:0] a, input bit exp_hit, input logic [31:0] exp_pa, input string req);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
    #1;
    check(rsp_valid && rsp_hit == exp_hit, req, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) check(rsp_paddr == exp_pa, req, rsp_paddr, exp_pa);
  endtask

  task automatic fill(input logic [31:0] a, input logic [19:0] f, input logic [31:0] m, input logic [2:0] acc);
    @(negedge clk); fill_valid = 1; fill_addr = a; fill_frame = f; fill_mask = m; fill_acc = acc;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic inval(input logic [31:0] a);
    @(negedge clk); inv_valid = 1; inv_addr = a;
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic sweep_and_count(output int n);
    @(negedge clk); flush_local = 1;
    @(negedge clk); flush_local = 0;
    n = 0;
    #1;
    while (busy && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  logic [31:0] lfsr = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R7 sweep may hang) actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1: reset state
    check(!busy && !large_present, "R1 reset flags", {busy, large_present}, 0);
    // R11: empty slots never hit, not even address 0 or 1
    look(32'h0000_0000, 0, 0, "R11 empty slot addr 0");
    look(32'h0000_0001, 0, 0, "R11 empty slot addr 1");
    look(32'h0000_3123, 0, 0, "R1 empty after reset");

    // R3/R4: 4 KiB fills and lookups
    fill(32'h0000_3000, 20'hABCDE, 32'hFFF, 3'b011);
    look(32'h0000_3123, 1, 32'hABCD_E123, "R3 4K hit offset 123");
    look(32'h0000_3FFF, 1, 32'hABCD_EFFF, "R3 4K hit offset FFF");
    look(32'h0001_3123, 0, 0, "R3 same index other tag");
    fill(32'h0000_5000, 20'h11111, 32'hFFF, 3'b100);
    @(negedge clk); #1;
    check(!large_present, "R5 small fill leaves flag", 32'(large_present), 0);

    // R5: large fill sets flag
    fill(32'h0040_7000, 20'h22200, 32'h001F_FFFF, 3'b100);
    #1;
    check(large_present, "R5 large fill sets flag", 32'(large_present), 1);
    look(32'h0040_7ABC, 1, 32'h2220_7ABC, "R3 2M hit");

    // R9: invalidate with flag set clears everything
    inval(32'h0000_9000);
    #1;
    check(!large_present, "R9 flag cleared", 32'(large_present), 0);
    look(32'h0000_3123, 0, 0, "R9 whole cache cleared");
    look(32'h0000_5000, 0, 0, "R9 global entry also cleared");

    // R10: single-slot invalidate
    fill(32'h0000_3000, 20'hABCDE, 32'hFFF, 3'b011);
    fill(32'h0000_4000, 20'h33333, 32'hFFF, 3'b000);
    inval(32'h0001_3000);
    look(32'h0000_3123, 1, 32'hABCD_E123, "R10 mismatched tag kept");
    inval(32'h0000_4FFF);
    look(32'h0000_4000, 0, 0, "R10 matching slot cleared");
    look(32'h0000_3010, 1, 32'hABCD_E010, "R10 other slot untouched");

    // R4: fill offered together with invalidate is refused
    @(negedge clk); fill_valid = 1; fill_addr = 32'h0000_6000; fill_frame = 20'h44444;
    fill_mask = 32'hFFF; fill_acc = 3'b000; inv_valid = 1; inv_addr = 32'h0000_E000;
    #1; check(!fill_ready, "R4 fill blocked by invalidate", 32'(fill_ready), 0);
    @(negedge clk); idle_all();
    look(32'h0000_6000, 0, 0, "R4 refused fill not written");

    // R7/R8: non-global sweep
    fill(32'h0000_5000, 20'h11111, 32'hFFF, 3'b100);
    fill(32'h0040_7000, 20'h22200, 32'h001F_FFFF, 3'b100);
    fill(32'h0060_9000, 20'h55400, 32'h001F_FFFF, 3'b000);
    @(negedge clk); lk_valid = 1; lk_addr = 32'h0000_5000;
    sweep_and_count(n);
    lk_valid = 0;
    check(n == 16, "R7 busy length", 32'(n), 32'd16);
    check(large_present, "R8 global large survives", 32'(large_present), 1);
    look(32'h0000_3123, 0, 0, "R7 non-global dropped");
    look(32'h0060_9000, 0, 0, "R7 non-global large dropped");
    look(32'h0000_5ABC, 1, 32'h1111_1ABC, "R7 global kept");
    look(32'h0040_7001, 1, 32'h2220_7001, "R7 global large kept");

    inval(32'h0000_0000);
    fill(32'h0000_5000, 20'h11111, 32'hFFF, 3'b100);
    fill(32'h0000_8000, 20'h66600, 32'h001F_FFFF, 3'b000);
    sweep_and_count(n);
    check(!large_present, "R8 flag rebuilt clear", 32'(large_present), 1'b0);
    look(32'h0000_5004, 1, 32'h1111_1004, "R7 global kept again");

    // R6: flush_all cuts a sweep short
    @(negedge clk); flush_local = 1;
    @(negedge clk); flush_local = 0;
    repeat (4) @(negedge clk);
    flush_all = 1;
    @(negedge clk); flush_all = 0;
    #1;
    check(!busy && walk_cache_clr, "R6 sweep aborted, walker told", {busy, walk_cache_clr}, 32'b01);
    @(negedge clk); #1;
    check(!walk_cache_clr, "R6 pulse one cycle", 32'(walk_cache_clr), 0);
    look(32'h0000_5004, 0, 0, "R6 global entry flushed");

    // R6: flush_all beats flush_local
    @(negedge clk); flush_all = 1; flush_local = 1;
    @(negedge clk); idle_all(); #1;
    check(!busy, "R6 flush_all has priority", 32'(busy), 0);

    // pseudo-random mix, compared every cycle against the model
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r, a;
      @(negedge clk);
      lfsr = nxt(lfsr); r = lfsr;
      lfsr = nxt(lfsr); a = lfsr & 32'hC060_FFFF;
      lk_valid    = r[0] | r[1];
      fill_valid  = r[2] & r[3];
      inv_valid   = r[4] & r[5] & r[6];
      flush_local = (r[11:7] == 5'd0);
      flush_all   = (r[16:12] == 5'd0) && r[17];
      lk_addr     = a;
      fill_addr   = {a[31:16], a[15:12] ^ r[27:24], a[11:0]};
      inv_addr    = {a[31:16], r[31:28], a[11:0]};
      fill_frame  = lfsr[19:0] ^ r[31:12];
      case (r[19:18])
        2'd2:    fill_mask = 32'h001F_FFFF;
        2'd3:    fill_mask = 32'h3FFF_FFFF;
        default: fill_mask = 32'h0000_0FFF;
      endcase
      fill_acc = r[22:20];
    end
    @(negedge clk); idle_all();
    repeat (20) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule